// File: doc/BRIEF.md
# NRZ Run-Length Bit Stuffer and Destuffer

This block is a matched transmit and receive pair for a non-return-to-zero serial stream. It limits how long the line can stay at one level, so that a receiver recovering timing from edges always sees a transition within a bounded number of bit slots. The transmit half takes payload bits through a valid/ready handshake. Once a run of identical line bits reaches the run limit (five by default), it places one bit of the opposite value on the line. While it sends that extra bit it holds its input stalled. The extra bit carries no payload.

The receive half watches the same line. When the run limit is reached, it expects the next bit to be the complement. It drops that bit, so the bit never reaches the payload output. If the next bit repeats the run value instead, the receive half reports a stuffing violation. Both halves advance at most one bit per enable pulse. A frame-enable input turns stuffing on for the duration of a frame. While it is low, bits pass straight through and both run counters are held at zero.

Top module: `nrz_stuff_top`

## Requirements
- R1: After reset, `tx_ready` is high and `line_strobe`, `rx_valid` and `stuff_err` are low.
- R2: While `frame_en` is high, no more than five identical bits appear on the line in a row. After five identical bits, the next line bit is their complement.
- R3: `tx_ready` is low only while a stuffed bit is pending. It returns high after the single `bit_en` pulse that emits that bit. A payload bit is taken only when `bit_en`, `tx_valid` and `tx_ready` are all high in the same cycle.
- R4: A stuffed bit starts a new run of length one with its own value. For example, `11111` is followed by a stuffed `0`, and four further `0` bits then trigger a stuffed `1`.
- R5: `line_strobe` rises for exactly one cycle, in the cycle after a `bit_en` pulse that emits a bit. A pulse with `tx_valid` low and no stuffed bit pending emits nothing.
- R6: With `frame_en` high, the receiver drops a bit that follows five identical bits and differs from them. Passing any sequence through the stuffer and then the destuffer gives back the original sequence.
- R7: When the bit after five identical received bits has the same value, `stuff_err` pulses for one cycle. That bit is not delivered, and the receive run count restarts from zero.
- R8: While `frame_en` is low, the transmitter inserts nothing and the receiver drops nothing. Dropping `frame_en` clears both run counters, so a run does not continue across the gap.
- R9: `rx_valid` or `stuff_err` is high only in the cycle after an `rx_strobe`. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en | input | 1 | Stuffing enabled; low clears both run counters |
| bit_en | input | 1 | Transmit bit-slot pulse |
| tx_valid | input | 1 | Payload bit offered |
| tx_data | input | 1 | Payload bit value |
| tx_ready | output | 1 | Transmitter can take a payload bit this slot |
| line_bit | output | 1 | Serial line value |
| line_strobe | output | 1 | One-cycle pulse marking a new line bit |
| rx_strobe | input | 1 | Receive bit-slot pulse |
| rx_line | input | 1 | Received line value |
| rx_valid | output | 1 | One-cycle pulse marking a delivered payload bit |
| rx_data | output | 1 | Delivered payload bit |
| stuff_err | output | 1 | One-cycle pulse on a stuffing violation |

## Verification
The assertions check every cycle that the line run never exceeds five bits inside a frame, that the stall lasts one emitting slot, that line and receive pulses follow their enables, and that data and error pulses are mutually exclusive. The bench scenarios cover the round trip of random and directed sequences, the exact stuffed line image compared with a bench model, the restart of the run after a stuffed bit, the clearing of the counters across a frame gap, and the behaviour after an injected sixth identical bit. Whether a dropped bit is really withheld, and whether the receive count really restarts after an error, can only be seen from those sequences.

// File: rtl/nrz_stuff_pkg.sv
// Package: shared definitions for the NRZ stuffer/destuffer pair.
// Assumes: a run limit of at least two bits.
package nrz_stuff_pkg;

    // Outcome of one received line bit
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_KEEP = 2'd1,
        RX_DROP = 2'd2,
        RX_FAIL = 2'd3
    } rx_act_t;

    // Counter width needed to hold 0..limit
    function automatic int run_cnt_width(input int limit);
        return $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/nrz_run_track.sv
// Module: nrz_run_track
// Tracks the value and length of the current run of identical bits.
// Assumes: clr has priority over upd; the count saturates at RUN_LIMIT.
module nrz_run_track #(
    parameter int RUN_LIMIT = 5,
    parameter int CNT_W     = nrz_stuff_pkg::run_cnt_width(RUN_LIMIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic             bit_in,
    output logic [CNT_W-1:0] run_len,
    output logic             run_val
);

    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(RUN_LIMIT);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    // Run length and value update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_len <= '0;
            run_val <= 1'b0;
        end else if (upd) begin
            run_val <= bit_in;
            if (run_len == '0 || bit_in != run_val)
                run_len <= ONE_C;
            else if (run_len != LIMIT_C)
                run_len <= run_len + ONE_C;
        end
    end

endmodule

// File: rtl/nrz_stuff_tx.sv
// Module: nrz_stuff_tx
// Serialises payload bits onto the line. After RUN_LIMIT identical bits
// inside a frame, it emits one complementary bit and stalls the input
// for that slot.
// Assumes: bit_en is a single-cycle slot pulse; line outputs are registered.
module nrz_stuff_tx #(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_en,
    input  logic bit_en,
    input  logic tx_valid,
    input  logic tx_data,
    output logic tx_ready,
    output logic line_bit,
    output logic line_strobe
);

    localparam int CNT_W = nrz_stuff_pkg::run_cnt_width(RUN_LIMIT);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(RUN_LIMIT);

    logic [CNT_W-1:0] run_len;
    logic             run_val;
    logic             stall;
    logic             emit;
    logic             next_bit;

    // Decide whether this slot carries a stuffed bit, a payload bit or nothing
    always_comb begin
        stall    = frame_en && (run_len == LIMIT_C);
        emit     = bit_en && (stall || tx_valid);
        next_bit = stall ? ~run_val : tx_data;
    end

    assign tx_ready = ~stall;

    nrz_run_track #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (~frame_en),
        .upd     (emit),
        .bit_in  (next_bit),
        .run_len (run_len),
        .run_val (run_val)
    );

    // Register the line value and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_bit    <= 1'b0;
            line_strobe <= 1'b0;
        end else begin
            line_strobe <= emit;
            if (emit)
                line_bit <= next_bit;
        end
    end

endmodule

// File: rtl/nrz_stuff_rx.sv
// Module: nrz_stuff_rx
// Removes stuffed bits from the received line. A repeat of the run value
// where a stuffed bit is due raises a one-cycle error and restarts the run.
// Assumes: rx_strobe is a single-cycle slot pulse; outputs are registered.
module nrz_stuff_rx #(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_en,
    input  logic rx_strobe,
    input  logic rx_line,
    output logic rx_valid,
    output logic rx_data,
    output logic stuff_err
);

    import nrz_stuff_pkg::*;

    localparam int CNT_W = run_cnt_width(RUN_LIMIT);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(RUN_LIMIT);

    logic [CNT_W-1:0] run_len;
    logic             run_val;
    rx_act_t          act;

    // Classify the incoming bit
    always_comb begin
        act = RX_IDLE;
        if (rx_strobe) begin
            if (frame_en && run_len == LIMIT_C)
                act = (rx_line != run_val) ? RX_DROP : RX_FAIL;
            else
                act = RX_KEEP;
        end
    end

    nrz_run_track #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (~frame_en || act == RX_FAIL),
        .upd     (act == RX_KEEP || act == RX_DROP),
        .bit_in  (rx_line),
        .run_len (run_len),
        .run_val (run_val)
    );

    // Register delivered data and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid  <= 1'b0;
            rx_data   <= 1'b0;
            stuff_err <= 1'b0;
        end else begin
            rx_valid  <= (act == RX_KEEP);
            stuff_err <= (act == RX_FAIL);
            if (act == RX_KEEP)
                rx_data <= rx_line;
        end
    end

endmodule

// File: rtl/nrz_stuff_top.sv
// Module: nrz_stuff_top
// Top of the stuffer/destuffer pair. The halves share only frame_en; the
// line is looped outside, so the receive input can be driven separately.
// Assumes: synchronous active-low reset; one bit per enable pulse.
module nrz_stuff_top #(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_en,
    input  logic bit_en,
    input  logic tx_valid,
    input  logic tx_data,
    output logic tx_ready,
    output logic line_bit,
    output logic line_strobe,
    input  logic rx_strobe,
    input  logic rx_line,
    output logic rx_valid,
    output logic rx_data,
    output logic stuff_err
);

    nrz_stuff_tx #(.RUN_LIMIT(RUN_LIMIT)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_en    (frame_en),
        .bit_en      (bit_en),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_ready    (tx_ready),
        .line_bit    (line_bit),
        .line_strobe (line_strobe)
    );

    nrz_stuff_rx #(.RUN_LIMIT(RUN_LIMIT)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_en  (frame_en),
        .rx_strobe (rx_strobe),
        .rx_line   (rx_line),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .stuff_err (stuff_err)
    );

endmodule

// File: rtl/nrz_stuff_chk.sv
// Module: nrz_stuff_chk
// Property checker bound to nrz_stuff_top. It keeps its own view of the
// line run, built only from the line ports.
// Assumes: frame_en stays stable while a frame is on the line.
module nrz_stuff_chk #(
    parameter int RUN_LIMIT = 5
) (
    input logic clk,
    input logic rst_n,
    input logic frame_en,
    input logic bit_en,
    input logic tx_valid,
    input logic tx_data,
    input logic tx_ready,
    input logic line_bit,
    input logic line_strobe,
    input logic rx_strobe,
    input logic rx_line,
    input logic rx_valid,
    input logic rx_data,
    input logic stuff_err
);

    localparam int CNT_W = $clog2(RUN_LIMIT + 2);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(RUN_LIMIT);

    logic [CNT_W-1:0] seen_len;
    logic             seen_val;

    // Observed line run, cleared outside frames
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_en) begin
            seen_len <= '0;
            seen_val <= 1'b0;
        end else if (line_strobe) begin
            seen_val <= line_bit;
            if (seen_len == '0 || line_bit != seen_val)
                seen_len <= CNT_W'(1);
            else
                seen_len <= seen_len + CNT_W'(1);
        end
    end

    // R2: a sixth identical bit never reaches the line inside a frame
    a_r2_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && frame_en && $past(frame_en) && seen_len == LIMIT_C)
            |-> (line_bit != seen_val));

    // R3: the stall is released by the one slot that emits the stuffed bit
    a_r3_stall_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !tx_ready) |=> (tx_ready && line_strobe));

    // R5: a line strobe always follows a bit_en pulse
    a_r5_strobe_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        line_strobe |-> $past(bit_en));

    // R5: no line bit without payload or pending stuff
    a_r5_quiet_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !tx_valid && tx_ready) |=> !line_strobe);

    // R9: receive outputs follow a receive strobe
    a_r9_rx_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || stuff_err) |-> $past(rx_strobe));

    // R9: data and error never coincide
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && stuff_err));

    logic unused_ok;
    assign unused_ok = ^{tx_data, rx_line, rx_data};

endmodule

bind nrz_stuff_top nrz_stuff_chk #(.RUN_LIMIT(RUN_LIMIT)) u_chk (.*);

// File: tb/nrz_stuff_top_bench.sv
// Bench for nrz_stuff_top: random and directed sequences checked against
// a bench model of the stuffed line and against the original payload.
module nrz_stuff_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT = 5;

    typedef bit bq_t[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_en = 1'b0, bit_en = 1'b0, tx_valid = 1'b0, tx_data = 1'b0;
    logic tx_ready, line_bit, line_strobe, rx_valid, rx_data, stuff_err;
    logic inj = 1'b0, inj_strobe = 1'b0, inj_bit = 1'b0;
    logic rx_strobe, rx_line;

    assign rx_strobe = inj ? inj_strobe : line_strobe;
    assign rx_line   = inj ? inj_bit : line_bit;

    always #(CLK_PERIOD/2) clk = ~clk;

    nrz_stuff_top #(.RUN_LIMIT(LIMIT)) u_nrz_stuff_top (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .bit_en(bit_en),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .line_bit(line_bit), .line_strobe(line_strobe),
        .rx_strobe(rx_strobe), .rx_line(rx_line), .rx_valid(rx_valid),
        .rx_data(rx_data), .stuff_err(stuff_err)
    );

    int n_chk = 0, n_fail = 0, err_seen = 0;
    bit done = 0;
    bq_t line_q, rx_q;

    // Monitor: record outputs away from the active edge
    always @(negedge clk) begin
        if (line_strobe) line_q.push_back(line_bit);
        if (rx_valid)    rx_q.push_back(rx_data);
        if (stuff_err)   err_seen++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Bench model of the line image, including the closing stuffed bit
    function automatic bq_t stuff_model(bq_t q, bit fen);
        bq_t o;
        int len = 0;
        bit val = 0;
        foreach (q[i]) begin
            if (fen && len == LIMIT) begin
                val = ~val; o.push_back(val); len = 1;
            end
            if (len == 0 || q[i] != val) len = 1; else len++;
            val = q[i];
            o.push_back(q[i]);
        end
        if (fen && len == LIMIT) o.push_back(~val);
        return o;
    endfunction

    function automatic bit same(bq_t a, bq_t b);
        if (a.size() != b.size()) return 0;
        foreach (a[i]) if (a[i] != b[i]) return 0;
        return 1;
    endfunction

    // Offer bits through the handshake with random slot gaps
    task automatic send_bits(bq_t q);
        foreach (q[i]) begin
            bit acc;
            do begin
                @(negedge clk);
                tx_valid = 1'b1;
                tx_data  = q[i];
                bit_en   = ($urandom % 4) != 0;
                #1;
                acc = bit_en && tx_ready;
                @(posedge clk);
            end while (!acc);
        end
        @(negedge clk);
        tx_valid = 1'b0;
        bit_en   = 1'b0;
    endtask

    // Idle slots so a pending stuffed bit leaves, then let the pipe drain
    task automatic flush();
        repeat (3) begin
            @(negedge clk); bit_en = 1'b1;
        end
        @(negedge clk); bit_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_gap();
        @(negedge clk); frame_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frame(bq_t q, bit fen, string tag);
        line_q.delete(); rx_q.delete(); err_seen = 0;
        @(negedge clk); frame_en = fen;
        send_bits(q);
        flush();
        check(same(line_q, stuff_model(q, fen)), "R2", {tag, " line image size"},
              line_q.size(), stuff_model(q, fen).size());
        check(same(rx_q, q), "R6", {tag, " round trip size"}, rx_q.size(), q.size());
        check(err_seen == 0, "R7", {tag, " no false error"}, err_seen, 0);
        frame_gap();
    endtask

    task automatic inject(bit b);
        @(negedge clk); inj_strobe = 1'b1; inj_bit = b;
        @(negedge clk); inj_strobe = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bq_t q;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset values
        check(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
        check(line_strobe == 1'b0 && rx_valid == 1'b0 && stuff_err == 1'b0,
              "R1", "outputs quiet after reset", line_strobe | rx_valid | stuff_err, 0);
        rst_n = 1'b1;

        // R4: restart of the run after a stuffed bit
        q = '{1,1,1,1,1, 0,0,0,0, 1};
        run_frame(q, 1'b1, "R4 restart");
        check(line_q.size() == 12 && line_q[5] == 0 && line_q[10] == 1, "R4",
              "stuffed positions", line_q.size(), 12);

        // R3: ready low for exactly one emitting slot
        line_q.delete(); rx_q.delete();
        @(negedge clk); frame_en = 1'b1;
        send_bits('{1,1,1,1,1});
        #1;
        check(tx_ready == 1'b0, "R3", "ready low with stuff pending", tx_ready, 0);
        @(negedge clk); bit_en = 1'b0; tx_valid = 1'b1; tx_data = 1'b1;
        #1;
        check(tx_ready == 1'b0, "R3", "ready held without slot", tx_ready, 0);
        @(negedge clk); bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0; tx_valid = 1'b0;
        #1;
        check(tx_ready == 1'b1, "R3", "ready back after one slot", tx_ready, 1);
        check(line_q.size() == 6 && line_q[5] == 0, "R5", "one stuffed bit emitted",
              line_q.size(), 6);
        // R5: idle slot with no payload emits nothing
        @(negedge clk); bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0;
        repeat (3) @(negedge clk);
        check(line_q.size() == 6, "R5", "idle slot quiet", line_q.size(), 6);
        check(rx_q.size() == 5, "R6", "stuffed bit withheld", rx_q.size(), 5);
        frame_gap();

        // R8: pass-through with framing off
        run_frame('{1,1,1,1,1,1,1,1,0,0,0,0,0,0,0}, 1'b0, "R8 passthrough");

        // R8: counters cleared by a frame gap
        line_q.delete(); rx_q.delete();
        @(negedge clk); frame_en = 1'b1;
        send_bits('{1,1,1,1});
        repeat (4) @(negedge clk);
        frame_gap();
        @(negedge clk); frame_en = 1'b1;
        send_bits('{1,1});
        flush();
        check(line_q.size() == 6, "R8", "no stuff across gap", line_q.size(), 6);
        check(rx_q.size() == 6, "R8", "all bits delivered across gap", rx_q.size(), 6);
        frame_gap();

        // R7: injected sixth identical bit
        line_q.delete(); rx_q.delete(); err_seen = 0;
        @(negedge clk); frame_en = 1'b1; inj = 1'b1;
        repeat (6) inject(1'b1);
        repeat (2) @(negedge clk);
        check(err_seen == 1, "R7", "error pulse count", err_seen, 1);
        check(rx_q.size() == 5, "R7", "violating bit not delivered", rx_q.size(), 5);
        repeat (5) inject(1'b1);
        inject(1'b0);
        repeat (2) @(negedge clk);
        check(err_seen == 1, "R7", "run restarted after error", err_seen, 1);
        check(rx_q.size() == 10, "R7", "stuff after restart dropped", rx_q.size(), 10);
        inj = 1'b0;
        frame_gap();

        // R6: random sequences biased toward long runs
        for (int f = 0; f < 24; f++) begin
            bq_t r;
            int n = 1 + ($urandom % 60);
            bit v = $urandom % 2;
            for (int k = 0; k < n; k++) begin
                if ($urandom % 7 == 0) v = ~v;
                r.push_back(v);
            end
            run_frame(r, ($urandom % 5) != 0, "R6 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule